// File: doc/BRIEF.md
# Card Window Address Translator

This block sits between a host bus and a 16-bit card socket. It decides whether a host cycle falls inside one of the socket's address windows, and if so it forms the card-side address. The socket has two I/O windows and five memory windows. Each window carries an enable bit, a lower bound, an upper bound and an offset, all held outside the block. I/O windows compare every address bit, so they work at byte granularity. Memory windows compare only the page bits above bit 11, which gives 4 KB pages. The page offset passes through to the card unchanged.

The block is purely combinational. A host cycle qualified by `cyc_valid` is tested against the windows of its own space, and `cyc_is_mem` selects that space. The result settles into one of three selection outcomes. SEL_NONE is a miss, or no valid cycle. SEL_IO means an I/O window matched. SEL_MEM means a memory window matched. The outcome follows the inputs in the same cycle; nothing is stored. When several windows match, the lowest-numbered one is reported.

Top module: `card_win_xlat`

## Requirements
- R1: An I/O cycle hits I/O window i when `io_en[i]` is 1 and `start <= host_addr[15:0] <= stop`, with both bounds inclusive. Host address bits above 15 play no part in the I/O comparison.
- R2: A memory cycle hits memory window i when `mem_en[i]` is 1 and the page `host_addr[23:12]` lies between that window's start page and stop page, both inclusive. The card address bits [11:0] equal `host_addr[11:0]`.
- R3: On an I/O hit, `card_addr` is `(host_addr[15:0] + offset) mod 2^16`, zero-extended. On a memory hit, `card_addr[25:12]` is `(page + page offset) mod 2^14`.
- R4: When several windows of the same space match, `win_idx` reports the lowest-numbered one, and `card_addr` uses that window's offset.
- R5: A window whose stop value is below its start value never hits. A window whose start equals its stop covers exactly one address for I/O, or one page for memory.
- R6: A window whose enable bit is 0 never hits, whatever its bounds.
- R7: An I/O cycle (`cyc_is_mem` = 0) tests only the I/O windows. A memory cycle (`cyc_is_mem` = 1) tests only the memory windows.
- R8: On a miss, or whenever `cyc_valid` is 0, `hit` is 0, `win_idx` is 0 and `card_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cyc_valid | input | 1 | A host cycle is present |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| host_addr | input | 24 | Host address; I/O cycles use bits [15:0] |
| io_en | input | 2 | Enable bit for each I/O window |
| io_start | input | 32 | Lower bound for each I/O window, 16 bits per window |
| io_stop | input | 32 | Upper bound for each I/O window, 16 bits per window |
| io_offset | input | 32 | Offset for each I/O window, 16 bits per window |
| mem_en | input | 5 | Enable bit for each memory window |
| mem_start | input | 60 | Start page for each memory window, 12 bits per window |
| mem_stop | input | 60 | Stop page for each memory window, 12 bits per window |
| mem_offset | input | 70 | Page offset for each memory window, 14 bits per window |
| hit | output | 1 | A window of the cycle's space matched |
| win_idx | output | 3 | Number of the matching window within its space |
| card_addr | output | 26 | Translated card address |

## Verification
The checks assume that every input is a known 0 or 1 and that the window settings are stable while a cycle is probed. They also assume the card address is at least as wide as the I/O address, so the upper bits of an I/O translation are zero. The bench changes settings only between probes and samples away from the clock edge. It drives all settings from defined values and clears every window between scenarios. Overlapping, inverted, single-unit and wrapping windows are built on purpose, so that each check has one expected value worked out by hand.

// File: rtl/cwx_pkg.sv
package cwx_pkg;
    localparam int IO_NWIN  = 2;
    localparam int MEM_NWIN = 5;
    localparam int IO_AW    = 16;
    localparam int MEM_AW   = 24;
    localparam int CARD_AW  = 26;
    localparam int PAGE_LSB = 12;

    // Which space, if any, supplies the result of the current cycle
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_IO   = 2'd1,
        SEL_MEM  = 2'd2
    } sel_e;
endpackage

// File: rtl/cwx_window.sv
// One window: inclusive range compare plus offset adder.
module cwx_window #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [CW-1:0] off,
    output logic          match,
    output logic [CW-1:0] xlat
);
    always_comb begin
        // An inverted range (hi < lo) can never satisfy both bounds
        match = en && (addr >= lo) && (addr <= hi);
        xlat  = CW'(addr) + off;
    end
endmodule

// File: rtl/cwx_first_hit.sv
// Lowest-index-wins selector over N candidate windows.
module cwx_first_hit #(
    parameter int N  = 2,
    parameter int W  = 16,
    parameter int IW = 3
) (
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] data,
    output logic           any,
    output logic [IW-1:0]  idx,
    output logic [W-1:0]   sel
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
                sel = data[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/card_win_xlat.sv
module card_win_xlat
    import cwx_pkg::*;
#(
    parameter int IO_N   = IO_NWIN,
    parameter int MEM_N  = MEM_NWIN,
    parameter int IOW    = IO_AW,
    parameter int MAW    = MEM_AW,
    parameter int CAW    = CARD_AW,
    parameter int PLSB   = PAGE_LSB,
    localparam int HPG_W = MAW - PLSB,
    localparam int CPG_W = CAW - PLSB,
    localparam int NMAX  = (IO_N > MEM_N) ? IO_N : MEM_N,
    localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1
) (
    input  logic                   cyc_valid,
    input  logic                   cyc_is_mem,
    input  logic [MAW-1:0]         host_addr,
    input  logic [IO_N-1:0]        io_en,
    input  logic [IO_N*IOW-1:0]    io_start,
    input  logic [IO_N*IOW-1:0]    io_stop,
    input  logic [IO_N*IOW-1:0]    io_offset,
    input  logic [MEM_N-1:0]       mem_en,
    input  logic [MEM_N*HPG_W-1:0] mem_start,
    input  logic [MEM_N*HPG_W-1:0] mem_stop,
    input  logic [MEM_N*CPG_W-1:0] mem_offset,
    output logic                   hit,
    output logic [IDX_W-1:0]       win_idx,
    output logic [CAW-1:0]         card_addr
);
    logic [IO_N-1:0]        io_match;
    logic [IO_N*IOW-1:0]    io_xlat;
    logic [MEM_N-1:0]       mem_match;
    logic [MEM_N*CPG_W-1:0] mem_xlat;

    logic                   io_any,  mem_any;
    logic [IDX_W-1:0]       io_idx,  mem_idx;
    logic [IOW-1:0]         io_sel;
    logic [CPG_W-1:0]       mem_sel;
    sel_e                   sel;

    logic [IOW-1:0]   io_addr;
    logic [HPG_W-1:0] mem_page;
    assign io_addr  = host_addr[IOW-1:0];
    assign mem_page = host_addr[MAW-1:PLSB];

    for (genvar g = 0; g < IO_N; g++) begin : g_io
        cwx_window #(.AW(IOW), .CW(IOW)) win_i (
            .en    (io_en[g]),
            .addr  (io_addr),
            .lo    (io_start[g*IOW +: IOW]),
            .hi    (io_stop[g*IOW +: IOW]),
            .off   (io_offset[g*IOW +: IOW]),
            .match (io_match[g]),
            .xlat  (io_xlat[g*IOW +: IOW])
        );
    end

    for (genvar g = 0; g < MEM_N; g++) begin : g_mem
        cwx_window #(.AW(HPG_W), .CW(CPG_W)) win_i (
            .en    (mem_en[g]),
            .addr  (mem_page),
            .lo    (mem_start[g*HPG_W +: HPG_W]),
            .hi    (mem_stop[g*HPG_W +: HPG_W]),
            .off   (mem_offset[g*CPG_W +: CPG_W]),
            .match (mem_match[g]),
            .xlat  (mem_xlat[g*CPG_W +: CPG_W])
        );
    end

    cwx_first_hit #(.N(IO_N), .W(IOW), .IW(IDX_W)) io_pick_i (
        .req  (io_match),
        .data (io_xlat),
        .any  (io_any),
        .idx  (io_idx),
        .sel  (io_sel)
    );

    cwx_first_hit #(.N(MEM_N), .W(CPG_W), .IW(IDX_W)) mem_pick_i (
        .req  (mem_match),
        .data (mem_xlat),
        .any  (mem_any),
        .idx  (mem_idx),
        .sel  (mem_sel)
    );

    // Space selection: only the windows of the cycle's own space count
    always_comb begin
        sel = SEL_NONE;
        if (cyc_valid) begin
            if (cyc_is_mem) begin
                if (mem_any) sel = SEL_MEM;
            end else begin
                if (io_any) sel = SEL_IO;
            end
        end
    end

    always_comb begin
        hit       = 1'b0;
        win_idx   = '0;
        card_addr = '0;
        unique case (sel)
            SEL_NONE: ;
            SEL_IO: begin
                hit       = 1'b1;
                win_idx   = io_idx;
                card_addr = CAW'(io_sel);
            end
            SEL_MEM: begin
                hit       = 1'b1;
                win_idx   = mem_idx;
                card_addr = {mem_sel, host_addr[PLSB-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/card_win_xlat_chk.sv
module card_win_xlat_chk #(
    parameter int IO_N   = 2,
    parameter int MEM_N  = 5,
    parameter int IOW    = 16,
    parameter int MAW    = 24,
    parameter int CAW    = 26,
    parameter int PLSB   = 12,
    parameter int IDX_W  = 3,
    localparam int HPG_W = MAW - PLSB,
    localparam int CPG_W = CAW - PLSB
) (
    input logic                   cyc_valid,
    input logic                   cyc_is_mem,
    input logic [MAW-1:0]         host_addr,
    input logic [IO_N-1:0]        io_en,
    input logic [IO_N*IOW-1:0]    io_start,
    input logic [IO_N*IOW-1:0]    io_stop,
    input logic [IO_N*IOW-1:0]    io_offset,
    input logic [MEM_N-1:0]       mem_en,
    input logic [MEM_N*HPG_W-1:0] mem_start,
    input logic [MEM_N*HPG_W-1:0] mem_stop,
    input logic [MEM_N*CPG_W-1:0] mem_offset,
    input logic                   hit,
    input logic [IDX_W-1:0]       win_idx,
    input logic [CAW-1:0]         card_addr
);
    logic             w_en_io, w_en_mem;
    logic [IOW-1:0]   w_lo_io, w_hi_io, w_off_io, io_a;
    logic [HPG_W-1:0] w_lo_mem, w_hi_mem, pg;
    logic [IOW-1:0]   io_expect;

    always_comb begin
        w_en_io = 1'b0; w_lo_io = '0; w_hi_io = '0; w_off_io = '0;
        w_en_mem = 1'b0; w_lo_mem = '0; w_hi_mem = '0;
        for (int i = 0; i < IO_N; i++) begin
            if (int'(win_idx) == i) begin
                w_en_io  = io_en[i];
                w_lo_io  = io_start[i*IOW +: IOW];
                w_hi_io  = io_stop[i*IOW +: IOW];
                w_off_io = io_offset[i*IOW +: IOW];
            end
        end
        for (int i = 0; i < MEM_N; i++) begin
            if (int'(win_idx) == i) begin
                w_en_mem = mem_en[i];
                w_lo_mem = mem_start[i*HPG_W +: HPG_W];
                w_hi_mem = mem_stop[i*HPG_W +: HPG_W];
            end
        end
        io_a      = host_addr[IOW-1:0];
        pg        = host_addr[MAW-1:PLSB];
        io_expect = io_a + w_off_io;
    end

    always_comb begin
        // R8
        miss_zero_chk: assert (hit || (card_addr == '0 && win_idx == '0));
        // R8
        valid_gate_chk: assert (!hit || cyc_valid);
        // R7
        io_space_chk: assert (!(hit && !cyc_is_mem) ||
                              (int'(win_idx) < IO_N && (card_addr >> IOW) == '0));
        // R7
        mem_space_chk: assert (!(hit && cyc_is_mem) || int'(win_idx) < MEM_N);
        // R6
        enabled_chk: assert (!hit || (cyc_is_mem ? w_en_mem : w_en_io));
        // R1
        io_range_chk: assert (!(hit && !cyc_is_mem) ||
                              (io_a >= w_lo_io && io_a <= w_hi_io));
        // R5
        order_chk: assert (!hit || (cyc_is_mem ? (w_lo_mem <= w_hi_mem)
                                               : (w_lo_io <= w_hi_io)));
        // R2
        page_pass_chk: assert (!(hit && cyc_is_mem) ||
                               (card_addr[PLSB-1:0] == host_addr[PLSB-1:0] &&
                                pg >= w_lo_mem && pg <= w_hi_mem));
        // R3
        io_offset_chk: assert (!(hit && !cyc_is_mem) ||
                               card_addr[IOW-1:0] == io_expect);
    end
endmodule

bind card_win_xlat card_win_xlat_chk #(
    .IO_N (IO_N),
    .MEM_N(MEM_N),
    .IOW  (IOW),
    .MAW  (MAW),
    .CAW  (CAW),
    .PLSB (PLSB),
    .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/card_win_xlat_tb_top.sv
module card_win_xlat_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        cyc_valid, cyc_is_mem;
    logic [23:0] host_addr;
    logic [1:0]  io_en;
    logic [31:0] io_start, io_stop, io_offset;
    logic [4:0]  mem_en;
    logic [59:0] mem_start, mem_stop;
    logic [69:0] mem_offset;
    logic        hit;
    logic [2:0]  win_idx;
    logic [25:0] card_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    card_win_xlat dut_i (
        .cyc_valid(cyc_valid), .cyc_is_mem(cyc_is_mem), .host_addr(host_addr),
        .io_en(io_en), .io_start(io_start), .io_stop(io_stop), .io_offset(io_offset),
        .mem_en(mem_en), .mem_start(mem_start), .mem_stop(mem_stop),
        .mem_offset(mem_offset),
        .hit(hit), .win_idx(win_idx), .card_addr(card_addr)
    );

    task automatic clear_all();
        io_en = '0; io_start = '0; io_stop = '0; io_offset = '0;
        mem_en = '0; mem_start = '0; mem_stop = '0; mem_offset = '0;
        cyc_valid = 1'b0; cyc_is_mem = 1'b0; host_addr = '0;
    endtask

    task automatic set_io(int i, bit en, logic [15:0] s, logic [15:0] e, logic [15:0] o);
        io_en[i] = en;
        io_start[i*16 +: 16] = s;
        io_stop[i*16 +: 16] = e;
        io_offset[i*16 +: 16] = o;
    endtask

    task automatic set_mem(int i, bit en, logic [11:0] s, logic [11:0] e, logic [13:0] o);
        mem_en[i] = en;
        mem_start[i*12 +: 12] = s;
        mem_stop[i*12 +: 12] = e;
        mem_offset[i*14 +: 14] = o;
    endtask

    // Drive a cycle just after a rising edge, sample at the falling edge
    task automatic probe(bit v, bit mem, logic [23:0] a);
        @(posedge clk);
        cyc_valid = v; cyc_is_mem = mem; host_addr = a;
        @(negedge clk);
    endtask

    task automatic expect_out(string req, logic eh, logic [2:0] ei, logic [25:0] ec);
        n_chk++;
        if (hit !== eh || win_idx !== ei || card_addr !== ec) begin
            n_bad++;
            $display("FAIL %s: actual hit=%0b idx=%0d card=%h expected hit=%0b idx=%0d card=%h",
                     req, hit, win_idx, card_addr, eh, ei, ec);
        end
    endtask

    task automatic t_reset();
        clear_all();
        @(negedge clk);
        expect_out("R8 idle", 1'b0, 3'd0, 26'h0);
    endtask

    task automatic t_io_basic();
        clear_all();
        set_io(0, 1, 16'h0300, 16'h030F, 16'h1000);
        probe(1, 0, 24'h000300); expect_out("R1 io low bound", 1, 0, 26'h0001300);
        probe(1, 0, 24'h00030F); expect_out("R1 io high bound", 1, 0, 26'h000130F);
        probe(1, 0, 24'h000310); expect_out("R1 io above", 0, 0, 26'h0);
        probe(1, 0, 24'h0002FF); expect_out("R8 io below", 0, 0, 26'h0);
        probe(1, 0, 24'hAB0305); expect_out("R1 io upper bits ignored", 1, 0, 26'h0001305);
    endtask

    task automatic t_io_wrap();
        clear_all();
        set_io(1, 1, 16'hFF00, 16'hFFFF, 16'h0200);
        probe(1, 0, 24'h00FF10); expect_out("R3 io offset wrap", 1, 1, 26'h0000110);
    endtask

    task automatic t_mem_gran();
        clear_all();
        set_mem(2, 1, 12'h010, 12'h012, 14'h3F00);
        probe(1, 1, 24'h010000); expect_out("R2 mem first page", 1, 2, 26'h3F10000);
        probe(1, 1, 24'h012FFF); expect_out("R2 mem last byte", 1, 2, 26'h3F12FFF);
        probe(1, 1, 24'h013000); expect_out("R2 mem next page", 0, 0, 26'h0);
        set_mem(4, 1, 12'h015, 12'h015, 14'h3FF0);
        probe(1, 1, 24'h015ABC); expect_out("R3 mem page wrap", 1, 4, 26'h0005ABC);
    endtask

    task automatic t_priority();
        clear_all();
        set_mem(1, 1, 12'h100, 12'h1FF, 14'h0000);
        set_mem(3, 1, 12'h100, 12'h1FF, 14'h0100);
        probe(1, 1, 24'h150000); expect_out("R4 mem lowest wins", 1, 1, 26'h0150000);
        mem_en[1] = 1'b0;
        probe(1, 1, 24'h150000); expect_out("R6 disabled skipped", 1, 3, 26'h0250000);
        set_io(0, 1, 16'h0400, 16'h04FF, 16'h0000);
        set_io(1, 1, 16'h0480, 16'h05FF, 16'h8000);
        probe(1, 0, 24'h000490); expect_out("R4 io lowest wins", 1, 0, 26'h0000490);
        probe(1, 0, 24'h000500); expect_out("R4 io second only", 1, 1, 26'h0008500);
    endtask

    task automatic t_inverted();
        clear_all();
        set_mem(0, 1, 12'h300, 12'h2FF, 14'h0000);
        probe(1, 1, 24'h2FF000); expect_out("R5 inverted below", 0, 0, 26'h0);
        probe(1, 1, 24'h300000); expect_out("R5 inverted above", 0, 0, 26'h0);
        set_mem(0, 1, 12'h300, 12'h300, 14'h0000);
        probe(1, 1, 24'h300FFF); expect_out("R5 single page", 1, 0, 26'h0300FFF);
        set_io(1, 1, 16'h0040, 16'h0040, 16'h0001);
        probe(1, 0, 24'h000041); expect_out("R5 single io addr miss", 0, 0, 26'h0);
    endtask

    task automatic t_space_and_gate();
        clear_all();
        set_io(0, 1, 16'h0000, 16'hFFFF, 16'h0000);
        probe(1, 1, 24'h001234); expect_out("R7 mem cycle ignores io", 0, 0, 26'h0);
        probe(0, 0, 24'h001234); expect_out("R8 valid low", 0, 0, 26'h0);
        io_en = '0;
        set_mem(0, 1, 12'h000, 12'hFFF, 14'h0000);
        probe(1, 0, 24'h001234); expect_out("R7 io cycle ignores mem", 0, 0, 26'h0);
        set_io(1, 0, 16'h1000, 16'h1FFF, 16'h0000);
        probe(1, 0, 24'h001234); expect_out("R6 disabled io", 0, 0, 26'h0);
    endtask

    initial begin
        t_reset();
        t_io_basic();
        t_io_wrap();
        t_mem_gran();
        t_priority();
        t_inverted();
        t_space_and_gate();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule